// File: doc/BRIEF.md
# Circular Cell Queue Address Controller

This block keeps the address state of one circular queue whose cells live in external memory. Each cell is 64 bytes, so every address the block handles is a 19-bit cell index, which is byte address bits 24 down to 6. Software sets up the queue through a small register port while the queue is off. The setup covers the first and last cell of the window, the starting write and read pointers, two fill thresholds, and two enable flags. Software then raises the enable input. The block checks the setup before it starts and refuses one that is not usable.

While the queue runs, an enqueue request returns one of three answers: the cell index to write, a refusal because the queue is full, or a discard because of congestion. A cell is discarded when its loss-priority bit is set, discarding is enabled, and the fill has reached the discard threshold. A dequeue request returns the cell index to read, or an empty answer. When marking is enabled and the fill has reached the mark threshold, the dequeue answer also tells the caller to set the forward-congestion mark in the outgoing cell. The memory data path, the cell payload and scheduling between queues are outside this block.

Top module: `cellq_ctrl`

## Requirements
- R1: When reset ends, `active`, `cfg_err`, all acknowledge and answer outputs, and `fill` are 0.
- R2: While `q_en` is 1 and the queue is inactive, the setup is checked on every cycle. The setup is valid only if capacity (last minus first, plus one) is at least 4, the last index is not below the first, and both start pointers equal the first index. With a valid setup, `active` is 1 and `cfg_err` is 0 on the next cycle. With an invalid setup, `active` stays 0 and `cfg_err` is 1 on the next cycle. Dropping `q_en` clears both `active` and `cfg_err` on the next cycle.
- R3: Accepted enqueues return cell indices that start at the first index and count up by one. The index after the last one is the first index again.
- R4: When `fill` equals capacity, an enqueue gets `enq_ack`=1 with `enq_accept`=0 and `enq_discard`=0, whatever the loss-priority bit is. `fill` never exceeds capacity.
- R5: Successful dequeues return cell indices in the same wrapping order as enqueues. `fill` rises by one for each accepted enqueue and falls by one for each successful dequeue.
- R6: A dequeue when `fill` is 0 gives `deq_ack`=1 and `deq_valid`=0, and the read pointer does not move.
- R7: An enqueue is discarded (`enq_discard`=1, `enq_accept`=0) when all of these hold: discarding is enabled (flag register bit 1), `enq_clp` is 1, the queue is not full, and `fill` is at or above the discard threshold. Otherwise a cell that is not refused as full is accepted.
- R8: `deq_mark` is 1 exactly on a successful dequeue where marking is enabled (flag register bit 0) and `fill` is at or above the mark threshold.
- R9: Register writes while `q_en` or `active` is 1 are ignored. Register selects: 0 first index, 1 last index, 2 write start, 3 read start, 4 mark threshold, 5 discard threshold, 6 flags.
- R10: While inactive, requests produce no acknowledge. One cycle after `active` falls, `fill` is 0, and the next enable starts the pointers again from the start registers.
- R11: Each answer appears one cycle after its request. Decisions use the fill from before the operation, and an enqueue and a dequeue in the same cycle are both served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 19 | Register write value |
| q_en | input | 1 | Queue enable request |
| enq_req | input | 1 | Enqueue request |
| enq_clp | input | 1 | Loss-priority bit of the arriving cell |
| deq_req | input | 1 | Dequeue request |
| active | output | 1 | Queue running |
| cfg_err | output | 1 | Enable refused: invalid setup |
| fill | output | 20 | Current fill in cells |
| enq_ack | output | 1 | Enqueue answer valid |
| enq_accept | output | 1 | Cell accepted, `enq_addr` valid |
| enq_discard | output | 1 | Cell discarded by the congestion rule |
| enq_addr | output | 19 | Cell index to write |
| deq_ack | output | 1 | Dequeue answer valid |
| deq_valid | output | 1 | A cell is available at `deq_addr` |
| deq_mark | output | 1 | Set the forward-congestion mark on this cell |
| deq_addr | output | 19 | Cell index to read |

## Verification
The window and fill assertions assume that the first index, the last index and the capacity do not change while the queue is active. The block enforces this by blocking register writes. The empty-answer and full-answer properties assume that an acknowledge only follows a cycle in which the queue was active. The stimulus keeps thresholds between 0 and one above capacity, so both sides of each comparison are exercised. It places one window against the top of the 19-bit index space to test wrapping. It also attempts random register writes while the queue runs, and it never writes a register in the same cycle that `q_en` rises.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  localparam int unsigned CELL_IDX_W = 19;

  typedef enum logic [2:0] {
    SEL_FIRST = 3'd0,
    SEL_LAST  = 3'd1,
    SEL_WSTRT = 3'd2,
    SEL_RSTRT = 3'd3,
    SEL_MARK  = 3'd4,
    SEL_DROP  = 3'd5,
    SEL_FLAGS = 3'd6,
    SEL_NONE  = 3'd7
  } cfg_sel_e;
endpackage

// File: rtl/cellq_cfg.sv
module cellq_cfg
  import cellq_pkg::*;
#(
  parameter int unsigned IDX_W     = CELL_IDX_W,
  parameter int unsigned MIN_CELLS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [IDX_W-1:0] wdata,
  input  logic             q_en,
  output logic [IDX_W-1:0] first_o,
  output logic [IDX_W-1:0] last_o,
  output logic [IDX_W-1:0] wstrt_o,
  output logic [IDX_W-1:0] rstrt_o,
  output logic [IDX_W-1:0] mark_th_o,
  output logic [IDX_W-1:0] drop_th_o,
  output logic             mark_en_o,
  output logic             drop_en_o,
  output logic [IDX_W:0]   cap_o,
  output logic             active_o,
  output logic             err_o
);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] first_q, last_q, wstrt_q, rstrt_q, mark_q, drop_q;
  logic             men_q, den_q, act_q, err_q;
  logic [CNT_W-1:0] span;
  logic             setup_ok;

  // Capacity and validation come straight from the held registers.
  always_comb begin
    span     = {1'b0, last_q} - {1'b0, first_q};
    cap_o    = span + CNT_W'(1);
    setup_ok = (last_q >= first_q) &&
               (span >= CNT_W'(MIN_CELLS - 1)) &&
               (wstrt_q == first_q) &&
               (rstrt_q == first_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      wstrt_q <= '0;
      rstrt_q <= '0;
      mark_q  <= '0;
      drop_q  <= '0;
      men_q   <= 1'b0;
      den_q   <= 1'b0;
    end else if (we && !q_en && !act_q) begin
      unique case (cfg_sel_e'(sel))
        SEL_FIRST: first_q <= wdata;
        SEL_LAST:  last_q  <= wdata;
        SEL_WSTRT: wstrt_q <= wdata;
        SEL_RSTRT: rstrt_q <= wdata;
        SEL_MARK:  mark_q  <= wdata;
        SEL_DROP:  drop_q  <= wdata;
        SEL_FLAGS: begin
          men_q <= wdata[0];
          den_q <= wdata[1];
        end
        SEL_NONE:  ;
      endcase
    end
  end

  // Enable sequencing: the setup is re-checked each cycle while waiting.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
    end else if (!q_en) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
    end else if (!act_q) begin
      act_q <= setup_ok;
      err_q <= !setup_ok;
    end
  end

  assign first_o   = first_q;
  assign last_o    = last_q;
  assign wstrt_o   = wstrt_q;
  assign rstrt_o   = rstrt_q;
  assign mark_th_o = mark_q;
  assign drop_th_o = drop_q;
  assign mark_en_o = men_q;
  assign drop_en_o = den_q;
  assign active_o  = act_q;
  assign err_o     = err_q;
endmodule

// File: rtl/cellq_ptr.sv
module cellq_ptr #(
  parameter int unsigned IDX_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] init,
  input  logic             step,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_nx;

  always_comb begin
    if (ptr_q == last) ptr_nx = first;
    else               ptr_nx = ptr_q + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (load) ptr_q <= init;
    else if (step) ptr_q <= ptr_nx;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/cellq_gate.sv
module cellq_gate #(
  parameter int unsigned IDX_W = 19
) (
  input  logic             active,
  input  logic [IDX_W:0]   count,
  input  logic [IDX_W:0]   cap,
  input  logic [IDX_W-1:0] mark_th,
  input  logic [IDX_W-1:0] drop_th,
  input  logic             mark_en,
  input  logic             drop_en,
  input  logic             enq_req,
  input  logic             enq_clp,
  input  logic             deq_req,
  output logic             enq_seen,
  output logic             enq_take,
  output logic             enq_shed,
  output logic             deq_seen,
  output logic             deq_take,
  output logic             deq_flag
);
  logic full, empty, over_drop, over_mark;

  always_comb begin
    full      = (count == cap);
    empty     = (count == '0);
    over_drop = (count >= {1'b0, drop_th});
    over_mark = (count >= {1'b0, mark_th});
    enq_seen  = active && enq_req;
    enq_shed  = enq_seen && !full && drop_en && enq_clp && over_drop;
    enq_take  = enq_seen && !full && !enq_shed;
    deq_seen  = active && deq_req;
    deq_take  = deq_seen && !empty;
    deq_flag  = deq_take && mark_en && over_mark;
  end
endmodule

// File: rtl/cellq_ctrl.sv
module cellq_ctrl
  import cellq_pkg::*;
#(
  parameter int unsigned IDX_W     = CELL_IDX_W,
  parameter int unsigned MIN_CELLS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_wdata,
  input  logic             q_en,
  input  logic             enq_req,
  input  logic             enq_clp,
  input  logic             deq_req,
  output logic             active,
  output logic             cfg_err,
  output logic [IDX_W:0]   fill,
  output logic             enq_ack,
  output logic             enq_accept,
  output logic             enq_discard,
  output logic [IDX_W-1:0] enq_addr,
  output logic             deq_ack,
  output logic             deq_valid,
  output logic             deq_mark,
  output logic [IDX_W-1:0] deq_addr
);
  localparam int unsigned CNT_W  = IDX_W + 1;
  localparam int unsigned N_PTRS = 2;

  logic [IDX_W-1:0] first_w, last_w, wstrt_w, rstrt_w, mark_w, drop_w;
  logic             men_w, den_w, active_w, err_w;
  logic [CNT_W-1:0] cap_w;
  logic [CNT_W-1:0] count_q;
  logic             enq_seen, enq_take, enq_shed, deq_seen, deq_take, deq_flag;

  logic [N_PTRS-1:0][IDX_W-1:0] ptr_init;
  logic [N_PTRS-1:0][IDX_W-1:0] ptr_cur;
  logic [N_PTRS-1:0]            ptr_step;

  cellq_cfg #(.IDX_W(IDX_W), .MIN_CELLS(MIN_CELLS)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .q_en      (q_en),
    .first_o   (first_w),
    .last_o    (last_w),
    .wstrt_o   (wstrt_w),
    .rstrt_o   (rstrt_w),
    .mark_th_o (mark_w),
    .drop_th_o (drop_w),
    .mark_en_o (men_w),
    .drop_en_o (den_w),
    .cap_o     (cap_w),
    .active_o  (active_w),
    .err_o     (err_w)
  );

  cellq_gate #(.IDX_W(IDX_W)) u_gate (
    .active   (active_w),
    .count    (count_q),
    .cap      (cap_w),
    .mark_th  (mark_w),
    .drop_th  (drop_w),
    .mark_en  (men_w),
    .drop_en  (den_w),
    .enq_req  (enq_req),
    .enq_clp  (enq_clp),
    .deq_req  (deq_req),
    .enq_seen (enq_seen),
    .enq_take (enq_take),
    .enq_shed (enq_shed),
    .deq_seen (deq_seen),
    .deq_take (deq_take),
    .deq_flag (deq_flag)
  );

  // Index 0 is the write pointer, index 1 the read pointer.
  always_comb begin
    ptr_init[0] = wstrt_w;
    ptr_init[1] = rstrt_w;
    ptr_step[0] = enq_take;
    ptr_step[1] = deq_take;
  end

  for (genvar g = 0; g < N_PTRS; g++) begin : g_ptr
    cellq_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk   (clk),
      .rst   (rst),
      .load  (!active_w),
      .init  (ptr_init[g]),
      .step  (ptr_step[g]),
      .first (first_w),
      .last  (last_w),
      .ptr_o (ptr_cur[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !active_w) count_q <= '0;
    else count_q <= count_q + CNT_W'(enq_take) - CNT_W'(deq_take);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enq_ack     <= 1'b0;
      enq_accept  <= 1'b0;
      enq_discard <= 1'b0;
      enq_addr    <= '0;
      deq_ack     <= 1'b0;
      deq_valid   <= 1'b0;
      deq_mark    <= 1'b0;
      deq_addr    <= '0;
    end else begin
      enq_ack     <= enq_seen;
      enq_accept  <= enq_take;
      enq_discard <= enq_shed;
      enq_addr    <= ptr_cur[0];
      deq_ack     <= deq_seen;
      deq_valid   <= deq_take;
      deq_mark    <= deq_flag;
      deq_addr    <= ptr_cur[1];
    end
  end

  assign active  = active_w;
  assign cfg_err = err_w;
  assign fill    = count_q;
endmodule

// File: rtl/cellq_ctrl_chk.sv
module cellq_ctrl_chk #(
  parameter int unsigned IDX_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic             cfg_err,
  input logic [IDX_W:0]   fill,
  input logic [IDX_W:0]   cap,
  input logic [IDX_W-1:0] first,
  input logic [IDX_W-1:0] last,
  input logic             enq_ack,
  input logic             enq_accept,
  input logic             enq_discard,
  input logic [IDX_W-1:0] enq_addr,
  input logic             deq_ack,
  input logic             deq_valid,
  input logic             deq_mark,
  input logic [IDX_W-1:0] deq_addr
);
  a_r2_err_not_active: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !active);

  a_r3_enq_in_window: assert property (@(posedge clk) disable iff (rst)
    enq_accept |-> (enq_addr >= first && enq_addr <= last));

  a_r5_deq_in_window: assert property (@(posedge clk) disable iff (rst)
    deq_valid |-> (deq_addr >= first && deq_addr <= last));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    active |-> fill <= cap);

  a_r4_refuse_only_when_full: assert property (@(posedge clk) disable iff (rst)
    (enq_ack && !enq_accept && !enq_discard) |-> $past(fill) == $past(cap));

  a_r6_empty_answer: assert property (@(posedge clk) disable iff (rst)
    (deq_ack && !deq_valid) |-> $past(fill) == '0);

  a_r7_accept_excl_discard: assert property (@(posedge clk) disable iff (rst)
    !(enq_accept && enq_discard));

  a_r8_mark_needs_valid: assert property (@(posedge clk) disable iff (rst)
    deq_mark |-> deq_valid);

  a_r10_idle_no_ack: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!enq_ack && !deq_ack));

  a_r11_fill_step: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> (fill <= $past(fill) + 1'b1));
endmodule

bind cellq_ctrl cellq_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .active      (active),
  .cfg_err     (cfg_err),
  .fill        (fill),
  .cap         (cap_w),
  .first       (first_w),
  .last        (last_w),
  .enq_ack     (enq_ack),
  .enq_accept  (enq_accept),
  .enq_discard (enq_discard),
  .enq_addr    (enq_addr),
  .deq_ack     (deq_ack),
  .deq_valid   (deq_valid),
  .deq_mark    (deq_mark),
  .deq_addr    (deq_addr)
);

// File: tb/cellq_ctrl_test.sv
module cellq_ctrl_test;
  localparam int unsigned IDX_W = 19;
  localparam time CLK_PERIOD = 10ns;
  localparam longint TOP_IDX = (64'd1 << IDX_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_sel = '0;
  logic [IDX_W-1:0] cfg_wdata = '0;
  logic             q_en = 1'b0;
  logic             enq_req = 1'b0;
  logic             enq_clp = 1'b0;
  logic             deq_req = 1'b0;
  logic             active, cfg_err, enq_ack, enq_accept, enq_discard;
  logic             deq_ack, deq_valid, deq_mark;
  logic [IDX_W:0]   fill;
  logic [IDX_W-1:0] enq_addr, deq_addr;

  cellq_ctrl #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .q_en(q_en), .enq_req(enq_req), .enq_clp(enq_clp), .deq_req(deq_req),
    .active(active), .cfg_err(cfg_err), .fill(fill),
    .enq_ack(enq_ack), .enq_accept(enq_accept), .enq_discard(enq_discard), .enq_addr(enq_addr),
    .deq_ack(deq_ack), .deq_valid(deq_valid), .deq_mark(deq_mark), .deq_addr(deq_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model of the registers and queue state.
  longint m_first = 0, m_last = 0, m_ws = 0, m_rs = 0, m_mark = 0, m_drop = 0;
  bit     m_men = 0, m_den = 0, m_act = 0, m_qen = 0;
  longint m_fill = 0, m_wp = 0, m_rp = 0;

  function automatic longint cap_of();
    return m_last - m_first + 1;
  endfunction

  function automatic bit setup_valid();
    return (m_last >= m_first) && (cap_of() >= 4) && (m_ws == m_first) && (m_rs == m_first);
  endfunction

  function automatic longint next_idx(longint p);
    return (p == m_last) ? m_first : p + 1;
  endfunction

  task automatic check(string req, longint act_v, longint exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr_reg(int sel, longint val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = IDX_W'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (!m_act && !m_qen) begin
      case (sel)
        0: m_first = val;
        1: m_last = val;
        2: m_ws = val;
        3: m_rs = val;
        4: m_mark = val;
        5: m_drop = val;
        6: begin m_men = val[0]; m_den = val[1]; end
        default: ;
      endcase
    end
  endtask

  task automatic setup(longint f, longint l, longint mk, longint dr, int flags);
    wr_reg(0, f); wr_reg(1, l); wr_reg(2, f); wr_reg(3, f);
    wr_reg(4, mk); wr_reg(5, dr); wr_reg(6, flags);
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    q_en = v;
    @(posedge clk); #1;
    if (v) begin
      if (!m_act) begin
        if (setup_valid()) begin
          m_act = 1; m_wp = m_ws; m_rp = m_rs; m_fill = 0;
          check("R2 enable accepted cfg_err", cfg_err, 0);
        end else begin
          check("R2 enable refused cfg_err", cfg_err, 1);
        end
      end
      check("R2 active after enable", active, m_act);
    end else begin
      m_act = 0;
      check("R2 active cleared", active, 0);
      check("R2 cfg_err cleared", cfg_err, 0);
      @(posedge clk); #1;
      m_fill = 0;
      check("R10 fill cleared after disable", fill, 0);
    end
    m_qen = v;
  endtask

  task automatic op(bit e, bit c, bit d);
    bit full, shed, acc, dv, mk;
    @(negedge clk);
    enq_req = e; enq_clp = c; deq_req = d;
    @(posedge clk); #1;
    enq_req = 1'b0; enq_clp = 1'b0; deq_req = 1'b0;
    full = m_act && (m_fill == cap_of());
    shed = m_act && e && !full && m_den && c && (m_fill >= m_drop);
    acc  = m_act && e && !full && !shed;
    dv   = m_act && d && (m_fill != 0);
    mk   = dv && m_men && (m_fill >= m_mark);
    check("R10/R11 enq_ack", enq_ack, m_act && e);
    check("R4 enq_accept", enq_accept, acc);
    check("R7 enq_discard", enq_discard, shed);
    check("R10/R11 deq_ack", deq_ack, m_act && d);
    check("R6 deq_valid", deq_valid, dv);
    check("R8 deq_mark", deq_mark, mk);
    if (acc) begin
      check("R3 enq_addr", enq_addr, m_wp);
      m_wp = next_idx(m_wp);
    end
    if (dv) begin
      check("R5 deq_addr", deq_addr, m_rp);
      m_rp = next_idx(m_rp);
    end
    m_fill = m_fill + acc - dv;
    check("R5 fill", fill, m_fill);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_C311));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 active", active, 0);
    check("R1 cfg_err", cfg_err, 0);
    check("R1 fill", fill, 0);
    check("R1 enq_ack", enq_ack, 0);
    check("R1 deq_ack", deq_ack, 0);

    // R2: capacity 3 refused, last below first refused, bad start pointer refused.
    setup(100, 102, 0, 0, 0);
    set_en(1); check("R2 cap3 refused", active, 0);
    set_en(0);
    setup(200, 150, 0, 0, 0);
    set_en(1); check("R2 reversed refused", cfg_err, 1);
    set_en(0);
    setup(300, 303, 0, 0, 0);
    wr_reg(2, 301);
    set_en(1); check("R2 bad start refused", cfg_err, 1);
    set_en(0);
    // R10: requests while inactive give no acknowledge.
    op(1, 0, 1);
    wr_reg(2, 300);
    set_en(1); check("R2 cap4 accepted", active, 1);

    // R9: writes while active ignored (window stays 300..303).
    wr_reg(0, 500); wr_reg(1, 900);
    // R3/R4: fill four, then refuse regardless of clp.
    repeat (4) op(1, 0, 0);
    op(1, 0, 0);
    op(1, 1, 0);
    check("R4 full fill", fill, 4);
    // R5/R6: drain, then empty.
    repeat (4) op(0, 0, 1);
    op(0, 0, 1);
    // R3 wrap and R11 simultaneous.
    repeat (3) op(1, 0, 0);
    repeat (6) op(1, 0, 1);
    op(1, 1, 1);
    set_en(0);
    op(1, 0, 1);

    // Window against the top of the index space.
    setup(TOP_IDX - 5, TOP_IDX, 3, 4, 3);
    set_en(1);
    repeat (6) op(1, 0, 0);
    repeat (3) op(0, 0, 1);
    repeat (8) op(1, 1, 1);
    set_en(0);

    // R7/R8 directed thresholds.
    setup(1000, 1009, 2, 3, 3);
    set_en(1);
    op(1, 1, 0); op(1, 1, 0); op(1, 1, 0);
    op(1, 1, 0);
    check("R7 discard held fill", fill, 3);
    op(1, 0, 0);
    op(0, 0, 1); op(0, 0, 1); op(0, 0, 1); op(0, 0, 1);
    set_en(0);
    setup(1000, 1009, 2, 0, 0);
    set_en(1);
    repeat (4) op(1, 1, 0);
    repeat (4) op(0, 0, 1);
    set_en(0);

    // Random rounds.
    for (int r = 0; r < 24; r++) begin
      longint f, c;
      f = longint'($urandom_range(0, 400000));
      c = longint'($urandom_range(4, 40));
      setup(f, f + c - 1, longint'($urandom_range(0, 32'(c + 1))),
            longint'($urandom_range(0, 32'(c + 1))), int'($urandom_range(0, 3)));
      set_en(1);
      for (int k = 0; k < 150; k++) begin
        if ($urandom_range(0, 19) == 0)
          wr_reg(int'($urandom_range(0, 6)), longint'($urandom_range(0, 4000)));
        else
          op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      set_en(0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule